// File: doc/BRIEF.md
# Bit-Slice Lookup Dot-Product Unit (three taps, half-width time sharing)

This unit forms the weighted sum of three unsigned operands with three fixed coefficients without a single hardware multiplier. For every bit weight k, bit k of each operand is gathered into a 3-bit address. That address selects one entry of an 8-entry partial-product table, and each entry holds the sum of the coefficients whose operand bit is set. The selected entries are then shifted by their weight and summed.

Only four table read ports exist. A triple is therefore handled in two passes. The first clock looks up the four low bit weights and parks that partial sum in a register. The next clock looks up the four high weights, shifts that sum up by four and adds it to the parked value.

The table is written from outside through a simple write port, one entry per clock. The unit itself never derives entries from coefficients. A new triple may enter every second clock, and each accepted triple yields one result pulse.

Top module: `dot3_da_mul`

## Requirements
- R1: After reset, out_valid and out_res are 0 and every table entry is 0, so any triple accepted before a table write yields result 0.
- R2: A write with tbl_we high stores tbl_data at tbl_addr at the clock edge. Table address bit 2 belongs to operand in_a1, bit 1 to in_a2 and bit 0 to in_a3.
- R3: When each entry at address {b1,b2,b3} holds b1*c1 + b2*c2 + b3*c3, the result equals in_a1*c1 + in_a2*c2 + in_a3*c3.
- R4: For arbitrary table contents T, the result is the sum over k=0..7 of T[{in_a1[k],in_a2[k],in_a3[k]}] shifted left by k.
- R5: A triple accepted at clock edge E produces out_valid high for exactly the one cycle following edge E+2, with its result on out_res.
- R6: A triple is accepted when in_valid is high and the unit did not accept one at the previous edge. in_valid in the cycle right after an acceptance is ignored, so a held in_valid yields one acceptance per two clocks.
- R7: out_res keeps its last value while out_valid is low.
- R8: The result is the exact sum reduced modulo 2^16. For example, all operands 255 with all coefficients 255 gives 64003.
- R9: For 2-bit values, operands 1, 3, 2 with coefficients 3, 0, 2 give 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 3 | Table entry address, bit 2 = in_a1 slice bit |
| tbl_data | input | 10 | Table entry value |
| in_valid | input | 1 | Operand triple present |
| in_a1 | input | 8 | Operand 1 |
| in_a2 | input | 8 | Operand 2 |
| in_a3 | input | 8 | Operand 3 |
| out_valid | output | 1 | One-cycle result strobe |
| out_res | output | 16 | Dot-product result |

## Verification
A swapped slice address or a wrong half selection corrupts the very next result. It shows on out_res two clocks after acceptance, and the raw-table patterns make each of the eight weights give a distinct value. A stuck or skipped phase shows as a missing, doubled or early out_valid pulse within three clocks of acceptance. A streamed run exposes a triple that should have been ignored, because an extra strobe appears on the next odd cycle. A parked low-half value that is never updated shows as a stale low nibble contribution on the following triple.

// File: rtl/dot3_pkg.sv
package dot3_pkg;

  // Sequencer phase: idle, low nibble pass, high nibble pass
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2
  } phase_e;

  // Table address for one bit weight: operand 1 is the most significant bit
  function automatic logic [2:0] slice_addr(input logic b1, input logic b2, input logic b3);
    return {b1, b2, b3};
  endfunction

endpackage

// File: rtl/dot3_tbl.sv
module dot3_tbl #(
  parameter int TBLW = 10,
  parameter int NRD  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        waddr,
  input  logic [TBLW-1:0]   wdata,
  input  logic [NRD*3-1:0]  raddr,
  output logic [NRD*TBLW-1:0] rdata
);
  localparam int DEPTH = 8;

  logic [TBLW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NRD; g++) begin : g_rd
      assign rdata[g*TBLW +: TBLW] = mem[raddr[g*3 +: 3]];
    end
  endgenerate

  // R2
  tbl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/dot3_half.sv
module dot3_half #(
  parameter int TBLW = 10,
  parameter int NSL  = 4,
  parameter int HW   = TBLW + NSL
) (
  input  logic [NSL*TBLW-1:0] tdata,
  output logic [HW-1:0]       hsum
);
  localparam int NP = NSL / 2;
  localparam int PW = TBLW + 2;

  logic [PW-1:0] pr [NP];

  // x1/x2 stage: pair adjacent weights
  genvar g;
  generate
    for (g = 0; g < NP; g++) begin : g_pair
      assign pr[g] = PW'(tdata[(2*g)*TBLW +: TBLW])
                   + (PW'(tdata[(2*g+1)*TBLW +: TBLW]) << 1);
    end
  endgenerate

  // x4 stage: combine pairs
  always_comb begin
    hsum = '0;
    for (int i = 0; i < NP; i++) hsum = hsum + (HW'(pr[i]) << (2*i));
  end

endmodule

// File: rtl/dot3_seq.sv
module dot3_seq
  import dot3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic accept,
  output logic lo_step,
  output logic hi_step
);
  phase_e phase;

  assign lo_step = (phase == PH_LO);
  assign hi_step = (phase == PH_HI);
  assign accept  = in_valid && !lo_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= PH_IDLE;
    else if (accept)  phase <= PH_LO;
    else if (lo_step) phase <= PH_HI;
    else              phase <= PH_IDLE;
  end

  // R6
  accept_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);

  // R5
  lo_then_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_step |=> hi_step);

  // R5
  accept_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> lo_step);

endmodule

// File: rtl/dot3_da_mul.sv
module dot3_da_mul
  import dot3_pkg::*;
#(
  parameter int OPW   = 8,
  parameter int COEFW = 8,
  parameter int RESW  = 16,
  parameter int TBLW  = COEFW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tbl_we,
  input  logic [2:0]      tbl_addr,
  input  logic [TBLW-1:0] tbl_data,
  input  logic            in_valid,
  input  logic [OPW-1:0]  in_a1,
  input  logic [OPW-1:0]  in_a2,
  input  logic [OPW-1:0]  in_a3,
  output logic            out_valid,
  output logic [RESW-1:0] out_res
);
  localparam int NSL   = OPW / 2;
  localparam int HW    = TBLW + NSL;
  localparam int FULLW = HW + NSL;

  logic accept, lo_step, hi_step;
  logic [OPW-1:0] op1, op2, op3;
  logic [NSL*3-1:0]    raddr;
  logic [NSL*TBLW-1:0] rdata;
  logic [HW-1:0] hsum;
  logic [HW-1:0] lo_keep;
  logic [FULLW-1:0] full_sum;

  dot3_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .accept(accept), .lo_step(lo_step), .hi_step(hi_step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op1 <= '0; op2 <= '0; op3 <= '0;
    end else if (accept) begin
      op1 <= in_a1; op2 <= in_a2; op3 <= in_a3;
    end
  end

  // Slice address per read port: low weight on the low pass, high on the high pass
  genvar g;
  generate
    for (g = 0; g < NSL; g++) begin : g_slice
      logic [2:0] a_lo, a_hi;
      assign a_lo = slice_addr(op1[g], op2[g], op3[g]);
      assign a_hi = slice_addr(op1[g+NSL], op2[g+NSL], op3[g+NSL]);
      assign raddr[g*3 +: 3] = hi_step ? a_hi : a_lo;
    end
  endgenerate

  dot3_tbl #(.TBLW(TBLW), .NRD(NSL)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_data),
    .raddr(raddr), .rdata(rdata)
  );

  dot3_half #(.TBLW(TBLW), .NSL(NSL), .HW(HW)) u_half (
    .tdata(rdata), .hsum(hsum)
  );

  assign full_sum = FULLW'(lo_keep) + (FULLW'(hsum) << NSL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_keep   <= '0;
      out_valid <= 1'b0;
      out_res   <= '0;
    end else begin
      out_valid <= hi_step;
      if (lo_step) lo_keep <= hsum;
      if (hi_step) out_res <= full_sum[RESW-1:0];
    end
  end

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_step |=> out_valid);

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_step |=> $stable(out_res));

  // R6
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_step |=> ($stable(op1) && $stable(op2) && $stable(op3)));

endmodule

// File: tb/dot3_da_mul_test.sv
module dot3_da_mul_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [2:0] tbl_addr = '0;
  logic [9:0] tbl_data = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_a1 = '0, in_a2 = '0, in_a3 = '0;
  logic out_valid;
  logic [15:0] out_res;

  int checks = 0;
  int failures = 0;
  logic [9:0] tbl_model [8];

  always #4 clk = ~clk;

  dot3_da_mul uut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .in_valid(in_valid), .in_a1(in_a1), .in_a2(in_a2), .in_a3(in_a3),
    .out_valid(out_valid), .out_res(out_res)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dot_ref(input int x1, input int x2, input int x3,
                                 input int c1, input int c2, input int c3);
    return (x1*c1 + x2*c2 + x3*c3) % 65536;
  endfunction

  function automatic int raw_ref(input logic [7:0] x1, input logic [7:0] x2, input logic [7:0] x3);
    int s = 0;
    for (int k = 0; k < 8; k++) s += int'(tbl_model[{x1[k], x2[k], x3[k]}]) * (1 << k);
    return s % 65536;
  endfunction

  task automatic put_entry(input int a, input int v);
    tbl_we = 1'b1; tbl_addr = 3'(a); tbl_data = 10'(v);
    tbl_model[a] = 10'(v);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic load_coeffs(input int c1, input int c2, input int c3);
    for (int a = 0; a < 8; a++)
      put_entry(a, ((a >> 2) & 1) * c1 + ((a >> 1) & 1) * c2 + (a & 1) * c3);
  endtask

  task automatic run_one(input int x1, input int x2, input int x3, input int exp, input string req);
    in_valid = 1'b1; in_a1 = 8'(x1); in_a2 = 8'(x2); in_a3 = 8'(x3);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R5 early strobe", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 early strobe", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R5 strobe", int'(out_valid), 1);
    chk(int'(out_res) == exp, req, int'(out_res), exp);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 single pulse", int'(out_valid), 0);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    chk(out_res == 16'd0, "R1 result", int'(out_res), 0);
    for (int a = 0; a < 8; a++) tbl_model[a] = '0;
    run_one(255, 170, 85, 0, "R1 empty table");
  endtask

  task automatic t_example;
    load_coeffs(3, 0, 2);
    run_one(1, 3, 2, 7, "R9 small example");
  endtask

  task automatic t_dot;
    load_coeffs(17, 200, 5);
    run_one(10, 20, 30, dot_ref(10, 20, 30, 17, 200, 5), "R3 pattern a");
    run_one(255, 0, 1, dot_ref(255, 0, 1, 17, 200, 5), "R3 pattern b");
    load_coeffs(90, 1, 128);
    run_one(128, 129, 127, dot_ref(128, 129, 127, 90, 1, 128), "R3 pattern c");
  endtask

  task automatic t_write;
    load_coeffs(0, 0, 0);
    put_entry(4, 777);
    run_one(1, 0, 0, 777, "R2 bit2 to in_a1");
    run_one(0, 0, 1, 0, "R2 bit0 untouched");
    put_entry(1, 5);
    run_one(0, 0, 1, 5, "R2 bit0 to in_a3");
  endtask

  task automatic t_raw;
    int v [8] = '{3, 1000, 41, 512, 77, 999, 260, 1023};
    for (int a = 0; a < 8; a++) put_entry(a, v[a]);
    run_one(8'h5A, 8'hC3, 8'h0F, raw_ref(8'h5A, 8'hC3, 8'h0F), "R4 raw a");
    run_one(8'h80, 8'h01, 8'hF0, raw_ref(8'h80, 8'h01, 8'hF0), "R4 raw b");
    run_one(8'h37, 8'hE9, 8'h64, raw_ref(8'h37, 8'hE9, 8'h64), "R4 raw c");
  endtask

  task automatic t_wrap;
    load_coeffs(255, 255, 255);
    run_one(255, 255, 255, 64003, "R8 wrap");
  endtask

  task automatic t_stream;
    int e [6];
    int last;
    load_coeffs(9, 33, 250);
    for (int i = 0; i < 6; i++) e[i] = dot_ref(i*40+1, 255-i*7, i*3, 9, 33, 250);
    last = -1;
    for (int i = 0; i < 9; i++) begin
      if (i == 3 || i == 5 || i == 7) begin
        chk(out_valid == 1'b1, "R6 accepted strobe", int'(out_valid), 1);
        chk(int'(out_res) == e[i-3], "R6 accepted result", int'(out_res), e[i-3]);
        last = int'(out_res);
      end else begin
        chk(out_valid == 1'b0, "R6 ignored triple", int'(out_valid), 0);
        if (last >= 0) chk(int'(out_res) == last, "R7 hold", int'(out_res), last);
      end
      if (i < 6) begin
        in_valid = 1'b1; in_a1 = 8'(i*40+1); in_a2 = 8'(255-i*7); in_a3 = 8'(i*3);
      end else in_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 20000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_example;
    t_dot;
    t_write;
    t_raw;
    t_wrap;
    t_stream;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule